// File: doc/BRIEF.md
# Standby Entry and Wakeup Controller

This block sequences a small microcontroller into and out of its deepest power-down state. A sleep request from the CPU is honoured only when three mode bits agree. The standby-select bit must be 1, and both the low-speed-on bit and the watchdog prescaler-select bit must be 0. Once in standby, the block turns off the run clock and the oscillator enable. The reference clock that drives the block keeps running.

While in standby, the block watches a set of wake sources:

- the non-maskable interrupt, on a selectable edge;
- sixteen interrupt lines;
- sixteen keyboard lines;
- sixteen wake-event lines;
- a PS/2 interrupt;
- the reset pin.

Each maskable source is qualified by its own enable and by the CPU mask. A qualified event turns the oscillator on and starts a settling countdown whose length is chosen by a 3-bit field. When the countdown ends, the block restarts the clock and raises a one-cycle start-of-interrupt-handling strobe.

The reset pin follows a different path. Pulling it low turns on the oscillator and the clock immediately, in any state. Reset handling is requested when the pin returns high. The source of the latest wake is held in a status output until software reads it.

Top module: `stby_wake_ctl`

## Requirements
- R1: A sleep request moves the block into standby only when the standby-select bit is 1, the low-speed-on bit is 0 and the watchdog prescaler-select bit is 0. Any other combination leaves clkRun and oscEn high.
- R2: In standby, clkRun and oscEn are both 0, from the first cycle after the accepted sleep request.
- R3: After a qualified wake event, oscEn rises while clkRun stays 0 for exactly 2^(settleSel+8) reference cycles. Then clkRun returns to 1 together with a one-cycle irqStart pulse.
- R4: An interrupt line wakes the block only when its irqEn bit is 1 and cpuMask is 0.
- R5: A keyboard or wake-event line wakes the block only when its enable bit is 1 and cpuMask is 0.
- R6: nmiEdgeSel=0 makes a falling edge of nmiPin a wake event and nmiEdgeSel=1 a rising edge. The edge of the other polarity is ignored, and cpuMask has no effect on this source.
- R7: ps2Irq wakes the block only when cpuMask is 0.
- R8: rstPinN low in any state, including during settling, sets clkRun and oscEn to 1 within three reference cycles without raising irqStart. When the pin returns high, rstStart pulses for one cycle.
- R9: A further wake event during settling neither restarts nor shortens the countdown, and does not change wakeSrc.
- R10: wakeSrc encodes the source as 0 none, 1 NMI, 2 interrupt line, 3 keyboard, 4 wake-event, 5 PS/2, 6 reset pin. The priority order, highest first, is NMI, interrupt line, keyboard, wake-event, PS/2. The value is captured at wake and holds until a statusRd pulse clears it to 0. It is 0 after power-on reset.
- R11: Wake sources asserted while the block is running have no effect on the clocks or on wakeSrc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running low-rate reference clock |
| porN | input | 1 | Power-on reset of the block, active low, asynchronous |
| sleepReq | input | 1 | One-cycle sleep request from the CPU |
| stbySel | input | 1 | Standby-select mode bit |
| lowSpeedOn | input | 1 | Low-speed-on mode bit |
| wdtPrescSel | input | 1 | Watchdog prescaler-select bit |
| settleSel | input | 3 | Settling time select, 2^(n+8) cycles |
| nmiEdgeSel | input | 1 | NMI edge: 0 falling, 1 rising |
| cpuMask | input | 1 | CPU mask for maskable wake sources |
| nmiPin | input | 1 | Asynchronous NMI pin |
| irqPin | input | 16 | Asynchronous interrupt lines |
| irqEn | input | 16 | Per-line interrupt enables |
| kbdPin | input | 16 | Asynchronous keyboard lines |
| kbdEn | input | 16 | Keyboard input enables |
| wuePin | input | 16 | Asynchronous wake-event lines |
| wueEn | input | 16 | Wake-event input enables |
| ps2Irq | input | 1 | Asynchronous PS/2 interrupt |
| rstPinN | input | 1 | Asynchronous reset pin, active low |
| statusRd | input | 1 | Software read strobe that clears wakeSrc |
| clkRun | output | 1 | CPU and peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| irqStart | output | 1 | Start interrupt exception handling |
| rstStart | output | 1 | Start reset exception handling |
| wakeSrc | output | 3 | Latest wake source code |

## Verification
Most internal faults show up within the first wake after entry, as a wrong length of the low-clkRun/high-oscEn window.

- A stuck or misloaded settle counter makes that window measurably wrong in width.
- A wrong qualification term appears within three reference cycles of the stimulus. It shows either as a premature rise of oscEn or as oscEn staying low.
- A wrong state after reset shows as clkRun not returning within three cycles of the pin falling.
- A misplaced capture shows as wakeSrc disagreeing with the stimulated source on the first sample after wake.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_STANDBY, ST_SETTLE, ST_WAKE_IRQ, ST_RST_HOLD
  } stbyState_t;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_NMI   = 3'd1,
    SRC_IRQ   = 3'd2,
    SRC_KBD   = 3'd3,
    SRC_WUE   = 3'd4,
    SRC_PS2   = 3'd5,
    SRC_RESET = 3'd6
  } wakeSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic capWake;
    logic capReset;
  } dpCtl_t;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         porN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/stby_dp.sv
module stby_dp
  import stby_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 porN,
  input  dpCtl_t               strb,
  input  logic                 inStandby,
  input  logic [SEL_W-1:0]     settleSel,
  input  logic                 nmiEdgeSel,
  input  logic                 cpuMask,
  input  logic                 nmiPin,
  input  logic [NUM_LINES-1:0] irqPin,
  input  logic [NUM_LINES-1:0] irqEn,
  input  logic [NUM_LINES-1:0] kbdPin,
  input  logic [NUM_LINES-1:0] kbdEn,
  input  logic [NUM_LINES-1:0] wuePin,
  input  logic [NUM_LINES-1:0] wueEn,
  input  logic                 ps2Irq,
  input  logic                 rstPinN,
  input  logic                 statusRd,
  output logic                 wakeEvt,
  output logic                 rstLow,
  output logic                 cntZero,
  output logic [2:0]           wakeSrc
);
  localparam int SYNC_W = 3 * NUM_LINES + 3;
  localparam int CNT_W  = BASE_SHIFT + (1 << SEL_W) - 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

  logic [SYNC_W-1:0]    rawIn, syncIn;
  logic [NUM_LINES-1:0] irqS, kbdS, wueS;
  logic                 nmiS, ps2S, rstS, nmiPrev;
  logic                 nmiEdge, irqHit, kbdHit, wueHit, ps2Hit;
  logic [CNT_W-1:0]     cnt;
  wakeSrc_t             code, srcReg;

  assign rawIn = {rstPinN, nmiPin, ps2Irq, wuePin, kbdPin, irqPin};

  stby_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .porN(porN), .d(rawIn), .q(syncIn)
  );

  assign {rstS, nmiS, ps2S, wueS, kbdS, irqS} = syncIn;
  assign rstLow = !rstS;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) nmiPrev <= 1'b0;
    else       nmiPrev <= nmiS;
  end

  assign nmiEdge = nmiEdgeSel ? (nmiS && !nmiPrev) : (!nmiS && nmiPrev);
  assign irqHit  = (|(irqS & irqEn)) && !cpuMask;
  assign kbdHit  = (|(kbdS & kbdEn)) && !cpuMask;
  assign wueHit  = (|(wueS & wueEn)) && !cpuMask;
  assign ps2Hit  = ps2S && !cpuMask;

  // priority: later assignments win
  always_comb begin
    code = SRC_NONE;
    if (ps2Hit)  code = SRC_PS2;
    if (wueHit)  code = SRC_WUE;
    if (kbdHit)  code = SRC_KBD;
    if (irqHit)  code = SRC_IRQ;
    if (nmiEdge) code = SRC_NMI;
  end

  assign wakeEvt = inStandby && (code != SRC_NONE);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             cnt <= '0;
    else if (strb.loadCnt) cnt <= ~({CNT_W{1'b1}} << (BASE_SHIFT + int'(settleSel)));
    else if (strb.decCnt)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              srcReg <= SRC_NONE;
    else if (strb.capWake)  srcReg <= code;
    else if (strb.capReset) srcReg <= SRC_RESET;
    else if (statusRd)      srcReg <= SRC_NONE;
  end

  assign wakeSrc = srcReg;
endmodule

// File: rtl/stby_ctl.sv
module stby_ctl
  import stby_pkg::*;
(
  input  logic   clk,
  input  logic   porN,
  input  logic   sleepReq,
  input  logic   stbySel,
  input  logic   lowSpeedOn,
  input  logic   wdtPrescSel,
  input  logic   wakeEvt,
  input  logic   rstLow,
  input  logic   cntZero,
  output dpCtl_t strb,
  output logic   inStandby,
  output logic   clkRun,
  output logic   oscEn,
  output logic   irqStart,
  output logic   rstStart
);
  stbyState_t state, nextState;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (rstLow) begin
      nextState = ST_RST_HOLD;
    end else begin
      unique case (state)
        ST_RUN:
          if (sleepReq && stbySel && !lowSpeedOn && !wdtPrescSel)
            nextState = ST_STANDBY;
        ST_STANDBY:
          if (wakeEvt) begin
            nextState    = ST_SETTLE;
            strb.loadCnt = 1'b1;
            strb.capWake = 1'b1;
          end
        ST_SETTLE:
          if (cntZero) nextState = ST_WAKE_IRQ;
          else         strb.decCnt = 1'b1;
        ST_WAKE_IRQ:
          nextState = ST_RUN;
        ST_RST_HOLD: begin
          nextState     = ST_RUN;
          strb.capReset = 1'b1;
        end
        default:
          nextState = ST_RUN;
      endcase
    end
  end

  assign inStandby = (state == ST_STANDBY);
  assign clkRun    = (state != ST_STANDBY) && (state != ST_SETTLE);
  assign oscEn     = (state != ST_STANDBY);
  assign irqStart  = (state == ST_WAKE_IRQ);
  assign rstStart  = (state == ST_RST_HOLD) && !rstLow;
endmodule

// File: rtl/stby_wake_ctl.sv
module stby_wake_ctl
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        sleepReq,
  input  logic        stbySel,
  input  logic        lowSpeedOn,
  input  logic        wdtPrescSel,
  input  logic [2:0]  settleSel,
  input  logic        nmiEdgeSel,
  input  logic        cpuMask,
  input  logic        nmiPin,
  input  logic [15:0] irqPin,
  input  logic [15:0] irqEn,
  input  logic [15:0] kbdPin,
  input  logic [15:0] kbdEn,
  input  logic [15:0] wuePin,
  input  logic [15:0] wueEn,
  input  logic        ps2Irq,
  input  logic        rstPinN,
  input  logic        statusRd,
  output logic        clkRun,
  output logic        oscEn,
  output logic        irqStart,
  output logic        rstStart,
  output logic [2:0]  wakeSrc
);
  dpCtl_t strb;
  logic   inStandby, wakeEvt, rstLow, cntZero;

  stby_ctl u_ctl (
    .clk(clk), .porN(porN), .sleepReq(sleepReq), .stbySel(stbySel),
    .lowSpeedOn(lowSpeedOn), .wdtPrescSel(wdtPrescSel), .wakeEvt(wakeEvt),
    .rstLow(rstLow), .cntZero(cntZero), .strb(strb), .inStandby(inStandby),
    .clkRun(clkRun), .oscEn(oscEn), .irqStart(irqStart), .rstStart(rstStart)
  );

  stby_dp #(.NUM_LINES(16), .SEL_W(3), .BASE_SHIFT(8)) u_dp (
    .clk(clk), .porN(porN), .strb(strb), .inStandby(inStandby),
    .settleSel(settleSel), .nmiEdgeSel(nmiEdgeSel), .cpuMask(cpuMask),
    .nmiPin(nmiPin), .irqPin(irqPin), .irqEn(irqEn), .kbdPin(kbdPin),
    .kbdEn(kbdEn), .wuePin(wuePin), .wueEn(wueEn), .ps2Irq(ps2Irq),
    .rstPinN(rstPinN), .statusRd(statusRd), .wakeEvt(wakeEvt),
    .rstLow(rstLow), .cntZero(cntZero), .wakeSrc(wakeSrc)
  );
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk (
  input logic       clk,
  input logic       porN,
  input logic       sleepReq,
  input logic       stbySel,
  input logic       lowSpeedOn,
  input logic       wdtPrescSel,
  input logic       statusRd,
  input logic       clkRun,
  input logic       oscEn,
  input logic       irqStart,
  input logic       rstStart,
  input logic [2:0] wakeSrc
);
  p_entry_r1: assert property (@(posedge clk) disable iff (!porN)
    ($past(oscEn) && !oscEn) |-> $past(sleepReq && stbySel && !lowSpeedOn && !wdtPrescSel));

  p_gate_r2: assert property (@(posedge clk) disable iff (!porN)
    !oscEn |-> !clkRun);

  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!porN)
    irqStart |=> !irqStart);

  p_irq_after_settle_r3: assert property (@(posedge clk) disable iff (!porN)
    irqStart |-> ($past(oscEn) && !$past(clkRun) && clkRun));

  p_rst_clock_r8: assert property (@(posedge clk) disable iff (!porN)
    rstStart |-> (oscEn && clkRun && !irqStart));

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!porN)
    (wakeSrc != $past(wakeSrc)) |-> ($past(statusRd) || $past(rstStart) || $rose(oscEn)));
endmodule

bind stby_wake_ctl stby_wake_chk u_chk (
  .clk(clk), .porN(porN), .sleepReq(sleepReq), .stbySel(stbySel),
  .lowSpeedOn(lowSpeedOn), .wdtPrescSel(wdtPrescSel), .statusRd(statusRd),
  .clkRun(clkRun), .oscEn(oscEn), .irqStart(irqStart), .rstStart(rstStart),
  .wakeSrc(wakeSrc)
);

// File: tb/stby_wake_ctl_tb.sv
`timescale 1ns/1ps
module stby_wake_ctl_tb;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        sleepReq = 0, stbySel = 0, lowSpeedOn = 0, wdtPrescSel = 0;
  logic [2:0]  settleSel = 0;
  logic        nmiEdgeSel = 0, cpuMask = 0, nmiPin = 0;
  logic [15:0] irqPin = 0, irqEn = 0, kbdPin = 0, kbdEn = 0, wuePin = 0, wueEn = 0;
  logic        ps2Irq = 0, rstPinN = 1, statusRd = 0;
  logic        clkRun, oscEn, irqStart, rstStart;
  logic [2:0]  wakeSrc;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  stby_wake_ctl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseSleep(input logic s, input logic l, input logic w);
    stbySel = s; lowSpeedOn = l; wdtPrescSel = w; sleepReq = 1;
    cyc(1);
    sleepReq = 0;
  endtask

  task automatic enterStandby();
    pulseSleep(1, 0, 0);
    chk("R2 clkRun in standby", clkRun, 0);
    chk("R2 oscEn in standby", oscEn, 0);
  endtask

  task automatic readClear();
    statusRd = 1; cyc(1); statusRd = 0; cyc(1);
    chk("R10 cleared by read", wakeSrc, 0);
  endtask

  // waits for oscEn, measures the settling window, optional NMI pokes
  task automatic waitWake(input string req, input int expN, input int pokeAt);
    int t = 0;
    int n = 0;
    while (!oscEn && t < 20) begin cyc(1); t++; end
    chk({req, " oscEn rose"}, oscEn, 1);
    while (!clkRun && n < expN + 20) begin
      n++;
      if (n == pokeAt || n == pokeAt + 10) nmiPin = ~nmiPin;
      cyc(1);
    end
    chk({req, " settle length"}, n, expN);
    chk({req, " irqStart pulse"}, irqStart, 1);
    cyc(1);
    chk({req, " irqStart one cycle"}, irqStart, 0);
  endtask

  task automatic noWake(input string req);
    cyc(12);
    chk(req, oscEn, 0);
  endtask

  task t_reset();
    chk("R10 reset wakeSrc", wakeSrc, 0);
    chk("R1 reset clkRun", clkRun, 1);
    chk("R1 reset oscEn", oscEn, 1);
    chk("R3 reset irqStart", irqStart, 0);
    chk("R8 reset rstStart", rstStart, 0);
  endtask

  task t_entry();
    pulseSleep(1, 1, 0); cyc(2);
    chk("R1 lowSpeedOn blocks", clkRun & oscEn, 1);
    pulseSleep(1, 0, 1); cyc(2);
    chk("R1 wdtPrescSel blocks", clkRun & oscEn, 1);
    pulseSleep(0, 0, 0); cyc(2);
    chk("R1 stbySel=0 blocks", clkRun & oscEn, 1);
  endtask

  task t_nmi();
    settleSel = 0; nmiEdgeSel = 1; cpuMask = 1; nmiPin = 0;
    enterStandby();
    nmiPin = 1;
    waitWake("R6 rising NMI R3", 256, 0);
    chk("R10 NMI code", wakeSrc, 1);
    cyc(3);
    chk("R10 held", wakeSrc, 1);
    readClear();
    nmiEdgeSel = 0; nmiPin = 0; cyc(4);
    enterStandby();
    nmiPin = 1;
    noWake("R6 rising ignored with falling select");
    nmiPin = 0;
    waitWake("R6 falling NMI", 256, 0);
    chk("R10 NMI code falling", wakeSrc, 1);
    readClear();
    cpuMask = 0;
  endtask

  task t_irq();
    settleSel = 1;
    enterStandby();
    irqPin[5] = 1;
    noWake("R4 disabled line ignored");
    cpuMask = 1; irqEn[5] = 1;
    noWake("R4 masked line ignored");
    cpuMask = 0;
    waitWake("R4 enabled line wakes", 512, 0);
    chk("R10 IRQ code", wakeSrc, 2);
    irqPin = 0; irqEn = 0;
    readClear();
  endtask

  task t_kbd_wue();
    settleSel = 1;
    enterStandby();
    kbdPin[3] = 1;
    noWake("R5 disabled keyboard ignored");
    kbdEn[3] = 1;
    waitWake("R5 keyboard wakes", 512, 0);
    chk("R10 KBD code", wakeSrc, 3);
    kbdPin = 0; kbdEn = 0;
    readClear();
    enterStandby();
    cpuMask = 1; wuePin[15] = 1; wueEn[15] = 1;
    noWake("R5 masked wake-event ignored");
    cpuMask = 0;
    waitWake("R5 wake-event wakes", 512, 0);
    chk("R10 WUE code", wakeSrc, 4);
    wuePin = 0; wueEn = 0;
    readClear();
  endtask

  task t_ps2();
    settleSel = 0;
    enterStandby();
    cpuMask = 1; ps2Irq = 1;
    noWake("R7 masked PS/2 ignored");
    cpuMask = 0;
    waitWake("R7 PS/2 wakes", 256, 0);
    chk("R10 PS2 code", wakeSrc, 5);
    ps2Irq = 0;
    readClear();
  endtask

  task t_no_restart();
    settleSel = 3; nmiEdgeSel = 1; nmiPin = 0; cyc(4);
    enterStandby();
    kbdEn[0] = 1; kbdPin[0] = 1;
    waitWake("R9 NMI during settle", 2048, 100);
    chk("R9 source unchanged", wakeSrc, 3);
    kbdPin = 0; kbdEn = 0; nmiPin = 0;
    readClear();
  endtask

  task t_run_ignored();
    irqEn[1] = 1; irqPin[1] = 1; ps2Irq = 1;
    cyc(10);
    chk("R11 clkRun stays", clkRun, 1);
    chk("R11 wakeSrc untouched", wakeSrc, 0);
    irqPin = 0; irqEn = 0; ps2Irq = 0;
    cyc(4);
  endtask

  task t_reset_pin();
    settleSel = 7;
    enterStandby();
    rstPinN = 0; cyc(3);
    chk("R8 clocks on from standby", clkRun & oscEn, 1);
    cyc(10);
    chk("R8 no rstStart while low", rstStart, 0);
    rstPinN = 1; cyc(2);
    chk("R8 rstStart on release", rstStart, 1);
    cyc(1);
    chk("R8 rstStart one cycle", rstStart, 0);
    chk("R10 reset code", wakeSrc, 6);
    readClear();
    enterStandby();
    ps2Irq = 1; cyc(4); ps2Irq = 0;
    cyc(50);
    chk("R8 in settling", clkRun, 0);
    rstPinN = 0; cyc(3);
    chk("R8 reset overrides settling", clkRun & oscEn, 1);
    chk("R8 no irqStart", irqStart, 0);
    rstPinN = 1; cyc(2);
    chk("R8 rstStart after settling abort", rstStart, 1);
    cyc(1);
    chk("R10 reset code overrides", wakeSrc, 6);
    readClear();
  endtask

  initial begin
    cyc(3);
    porN = 1;
    cyc(1);
    t_reset();
    t_entry();
    t_nmi();
    t_irq();
    t_kbd_wue();
    t_ps2();
    t_no_restart();
    t_run_ignored();
    t_reset_pin();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule